// File: doc/BRIEF.md
# Locked Configuration Store with Companion Stream Port

This block is a small word-addressed store that behaves like a nonvolatile configuration memory with two separate data paths. The system side issues commands through a single command channel: write a word, read a word, engage the lock, or wipe the whole store. The companion side is a streaming output that carries the stored words, in address order, to a programmable device sharing the same package; that path never leads back to the system side.

A single lock bit governs both paths. Before the lock is engaged the system side has full read and write access and the stream cannot run. Once the lock is engaged the system side can do nothing but wipe the store, and the stream may be started. A wipe takes one cycle per word, reports itself on a busy output, returns every word to the blank value, and releases the lock, so the companion device stays unconfigured until the store is written and locked again. A wipe issued while the stream is running cancels the stream first.

Top module: `cfgmem_guard`

## Requirements
- R1: Command codes on `cmd_op` are 2'b00 write, 2'b01 read, 2'b10 engage lock, 2'b11 wipe. With the lock clear and no wipe running, a write stores `cmd_wdata` at `cmd_addr`, and a read pulses `rsp_valid` for one cycle in the cycle after the command with the stored word on `rsp_data`.
- R2: `cmd_reject` is a one-cycle pulse in the cycle after any command that was refused, and is low after every accepted command.
- R3: An engage-lock command with the lock clear raises `locked` in the next cycle; with the lock set, write and engage-lock commands leave the store unchanged and are refused.
- R4: A read with the lock set and no wipe running pulses `rsp_valid` in the next cycle with `rsp_data` equal to the fixed pattern FILL_WORD (default 16'hA5C3) and is refused.
- R5: A `xfer_go` pulse starts the stream only when the lock is set, no wipe is running and no wipe is accepted in the same cycle; otherwise it has no effect and `cfg_valid` stays low.
- R6: A started stream raises `cfg_valid` in the next cycle and presents words from address 0 upward, moving to the next address only on a cycle with `cfg_valid` and `cfg_ready` both high; word and valid hold while `cfg_ready` is low.
- R7: After the handshake of the last address, `cfg_valid` falls and `cfg_done` is high for exactly the next cycle; `cfg_done` is never high together with `cfg_valid`.
- R8: A wipe command is accepted whatever the lock state when no wipe is running; `busy` is then high for exactly DEPTH cycles starting the next cycle, after which every word reads the blank value ERASE_VAL (default 16'hFFFF) and `locked` is low.
- R9: Every command received while `busy` is high is refused and has no effect on the store, the lock or `rsp_valid`.
- R10: A wipe accepted while the stream runs drops `cfg_valid` in the next cycle, produces no `cfg_done`, and the wipe proceeds as in R8.
- R11: After reset `busy`, `locked`, `cfg_valid`, `cfg_done`, `rsp_valid` and `cmd_reject` are low and every word holds ERASE_VAL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 2 | Command code (R1) |
| cmd_addr | input | AW | Word address for write and read |
| cmd_wdata | input | DW | Data for a write |
| rsp_valid | output | 1 | Read response present |
| rsp_data | output | DW | Read response word |
| cmd_reject | output | 1 | Previous-cycle command was refused |
| busy | output | 1 | Wipe in progress |
| locked | output | 1 | Lock bit state |
| xfer_go | input | 1 | Request to start the companion stream |
| cfg_valid | output | 1 | Stream word present |
| cfg_data | output | DW | Stream word |
| cfg_ready | input | 1 | Companion accepts the stream word |
| cfg_done | output | 1 | Stream finished with its last word |

## Verification
Every result of this block is registered once: read responses, refusal pulses and lock changes appear in the cycle after the command edge, the stream's first word one cycle after `xfer_go`, `cfg_done` one cycle after the final handshake, and `busy` falls exactly DEPTH cycles after the wipe edge. The bench drives inputs on the falling edge, advances a behavioural model at the rising edge from the same inputs, and compares all outputs at the following falling edge, so each expected value is taken in the cycle it is due. Directed checks then measure the wipe length, the count of streamed words and the refused accesses at the ports.

// File: rtl/cfgmem_pkg.sv
package cfgmem_pkg;
    typedef enum logic [1:0] {
        OP_WRITE = 2'b00,
        OP_READ  = 2'b01,
        OP_LOCK  = 2'b10,
        OP_WIPE  = 2'b11
    } op_e;
endpackage

// File: rtl/cfgmem_store.sv
module cfgmem_store #(
    parameter int AW = 4,
    parameter int DW = 16,
    parameter logic [DW-1:0] ERASE_VAL = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr_a,
    output logic [DW-1:0] rd_data_a,
    input  logic [AW-1:0] rd_addr_b,
    output logic [DW-1:0] rd_data_b
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (wr_en) begin
            mem_d[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= ERASE_VAL;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data_a = mem_q[rd_addr_a];
    assign rd_data_b = mem_q[rd_addr_b];
endmodule

// File: rtl/cfgmem_stream.sv
module cfgmem_stream #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          abort,
    input  logic          ready,
    output logic          valid,
    output logic [AW-1:0] addr,
    output logic          done
);
    localparam logic [AW-1:0] LAST = {AW{1'b1}};

    typedef struct packed {
        logic          act;
        logic [AW-1:0] ptr;
        logic          done;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (abort) begin
            s_d.act = 1'b0;
            s_d.ptr = '0;
        end else if (s_q.act && ready) begin
            if (s_q.ptr == LAST) begin
                s_d.act  = 1'b0;
                s_d.ptr  = '0;
                s_d.done = 1'b1;
            end else begin
                s_d.ptr = s_q.ptr + 1'b1;
            end
        end else if (start && !s_q.act) begin
            s_d.act = 1'b1;
            s_d.ptr = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign valid = s_q.act;
    assign addr  = s_q.ptr;
    assign done  = s_q.done;
endmodule

// File: rtl/cfgmem_guard.sv
module cfgmem_guard #(
    parameter int AW = 4,
    parameter int DW = 16,
    parameter logic [DW-1:0] ERASE_VAL = '1,
    parameter logic [DW-1:0] FILL_WORD = 16'hA5C3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          cmd_reject,
    output logic          busy,
    output logic          locked,
    input  logic          xfer_go,
    output logic          cfg_valid,
    output logic [DW-1:0] cfg_data,
    input  logic          cfg_ready,
    output logic          cfg_done
);
    import cfgmem_pkg::*;

    localparam logic [AW-1:0] LAST = {AW{1'b1}};

    typedef struct packed {
        logic          lock;
        logic          wiping;
        logic [AW-1:0] sweep;
        logic          rv;
        logic [DW-1:0] rd;
        logic          rej;
    } ctl_t;

    ctl_t c_d, c_q;

    op_e           op;
    logic          wipe_acc;
    logic          go;
    logic          we;
    logic [AW-1:0] waddr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata_a;
    logic [DW-1:0] rdata_b;
    logic [AW-1:0] s_addr;

    always_comb begin
        op       = op_e'(cmd_op);
        wipe_acc = cmd_valid && (op == OP_WIPE) && !c_q.wiping;
        go       = xfer_go && c_q.lock && !c_q.wiping && !wipe_acc;
        c_d      = c_q;
        c_d.rv   = 1'b0;
        c_d.rej  = 1'b0;
        we       = 1'b0;
        waddr    = cmd_addr;
        wdata    = cmd_wdata;
        if (c_q.wiping) begin
            we    = 1'b1;
            waddr = c_q.sweep;
            wdata = ERASE_VAL;
            if (c_q.sweep == LAST) begin
                c_d.wiping = 1'b0;
                c_d.lock   = 1'b0;
                c_d.sweep  = '0;
            end else begin
                c_d.sweep = c_q.sweep + 1'b1;
            end
            c_d.rej = cmd_valid;
        end else if (cmd_valid) begin
            unique case (op)
                OP_WRITE: begin
                    if (c_q.lock) c_d.rej = 1'b1;
                    else          we      = 1'b1;
                end
                OP_READ: begin
                    c_d.rv = 1'b1;
                    if (c_q.lock) begin
                        c_d.rd  = FILL_WORD;
                        c_d.rej = 1'b1;
                    end else begin
                        c_d.rd = rdata_a;
                    end
                end
                OP_LOCK: begin
                    if (c_q.lock) c_d.rej  = 1'b1;
                    else          c_d.lock = 1'b1;
                end
                OP_WIPE: begin
                    c_d.wiping = 1'b1;
                    c_d.sweep  = '0;
                end
                default: c_d.rej = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    cfgmem_store #(.AW(AW), .DW(DW), .ERASE_VAL(ERASE_VAL)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (we),
        .wr_addr   (waddr),
        .wr_data   (wdata),
        .rd_addr_a (cmd_addr),
        .rd_data_a (rdata_a),
        .rd_addr_b (s_addr),
        .rd_data_b (rdata_b)
    );

    cfgmem_stream #(.AW(AW)) u_stream (
        .clk   (clk),
        .rst_n (rst_n),
        .start (go),
        .abort (wipe_acc),
        .ready (cfg_ready),
        .valid (cfg_valid),
        .addr  (s_addr),
        .done  (cfg_done)
    );

    assign cfg_data   = rdata_b;
    assign rsp_valid  = c_q.rv;
    assign rsp_data   = c_q.rd;
    assign cmd_reject = c_q.rej;
    assign busy       = c_q.wiping;
    assign locked     = c_q.lock;
endmodule

// File: rtl/cfgmem_guard_chk.sv
module cfgmem_guard_chk #(
    parameter int AW = 4,
    parameter int DW = 16,
    parameter logic [DW-1:0] FILL_WORD = 16'hA5C3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [1:0]    cmd_op,
    input logic          rsp_valid,
    input logic [DW-1:0] rsp_data,
    input logic          cmd_reject,
    input logic          busy,
    input logic          locked,
    input logic          cfg_valid,
    input logic [DW-1:0] cfg_data,
    input logic          cfg_ready,
    input logic          cfg_done
);
    import cfgmem_pkg::*;

    logic wipe_now;
    assign wipe_now = cmd_valid && (cmd_op == OP_WIPE) && !busy;

    assert_lock_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(cmd_valid && cmd_op == OP_LOCK));

    assert_locked_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !busy && cmd_valid && cmd_op == OP_READ)
        |=> (rsp_valid && rsp_data == FILL_WORD && cmd_reject));

    assert_start_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_valid) |-> ($past(locked) && !$past(busy)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && !cfg_ready && !wipe_now) |=> (cfg_valid && $stable(cfg_data)));

    assert_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |-> !cfg_valid);

    assert_wipe_unlock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !locked);

    assert_busy_refuse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> (cmd_reject && !rsp_valid));

    assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && wipe_now) |=> (!cfg_valid && !cfg_done && busy));
endmodule

bind cfgmem_guard cfgmem_guard_chk #(.AW(AW), .DW(DW), .FILL_WORD(FILL_WORD)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .cmd_reject (cmd_reject),
    .busy       (busy),
    .locked     (locked),
    .cfg_valid  (cfg_valid),
    .cfg_data   (cfg_data),
    .cfg_ready  (cfg_ready),
    .cfg_done   (cfg_done)
);

// File: tb/sim_cfgmem_guard.sv
module sim_cfgmem_guard;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int DEPTH = 1 << AW;
    localparam logic [DW-1:0] EV   = 16'hFFFF;
    localparam logic [DW-1:0] FILL = 16'hA5C3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = 2'b00;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          rsp_valid, cmd_reject, busy, locked, cfg_valid, cfg_done;
    logic [DW-1:0] rsp_data, cfg_data;
    logic          xfer_go = 1'b0;
    logic          cfg_ready = 1'b0;

    always #10 clk = ~clk;

    cfgmem_guard #(.AW(AW), .DW(DW), .ERASE_VAL(EV), .FILL_WORD(FILL)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .cmd_reject(cmd_reject), .busy(busy), .locked(locked),
        .xfer_go(xfer_go), .cfg_valid(cfg_valid), .cfg_data(cfg_data),
        .cfg_ready(cfg_ready), .cfg_done(cfg_done)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // behavioural reference state
    logic [DW-1:0] m_mem [DEPTH];
    bit            m_lock, m_rv, m_rej, m_act, m_done;
    logic [DW-1:0] m_rd;
    int            m_left, m_ptr;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        bit p_lock, p_busy, wipe_acc;
        p_lock   = m_lock;
        p_busy   = (m_left > 0);
        wipe_acc = cmd_valid && cmd_op == 2'b11 && !p_busy;
        m_rv = 0; m_rej = 0; m_done = 0;
        if (wipe_acc) begin
            m_act = 0; m_ptr = 0;
        end else if (m_act && cfg_ready) begin
            if (m_ptr == DEPTH - 1) begin m_act = 0; m_ptr = 0; m_done = 1; end
            else m_ptr++;
        end else if (xfer_go && p_lock && !p_busy && !m_act) begin
            m_act = 1; m_ptr = 0;
        end
        if (p_busy) begin
            if (cmd_valid) m_rej = 1;
            m_left--;
            if (m_left == 0) begin
                foreach (m_mem[i]) m_mem[i] = EV;
                m_lock = 0;
            end
        end else if (cmd_valid) begin
            case (cmd_op)
                2'b00: if (p_lock) m_rej = 1; else m_mem[cmd_addr] = cmd_wdata;
                2'b01: begin
                    m_rv = 1;
                    if (p_lock) begin m_rd = FILL; m_rej = 1; end
                    else m_rd = m_mem[cmd_addr];
                end
                2'b10: if (p_lock) m_rej = 1; else m_lock = 1;
                default: m_left = DEPTH;
            endcase
        end
    endtask

    task automatic compare();
        chk(busy == (m_left > 0), "R8 busy", busy, (m_left > 0));
        chk(locked == m_lock, "R3 locked", locked, m_lock);
        chk(rsp_valid == m_rv, "R1 rsp_valid", rsp_valid, m_rv);
        if (m_rv) chk(rsp_data == m_rd, m_lock ? "R4 rsp_data" : "R1 rsp_data", rsp_data, m_rd);
        chk(cmd_reject == m_rej, "R2 cmd_reject", cmd_reject, m_rej);
        chk(cfg_valid == m_act, "R6 cfg_valid", cfg_valid, m_act);
        if (m_act) chk(cfg_data == m_mem[m_ptr], "R6 cfg_data", cfg_data, m_mem[m_ptr]);
        chk(cfg_done == m_done, "R7 cfg_done", cfg_done, m_done);
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
        cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
        step();
        cmd_valid = 0;
    endtask

    task automatic run_stream(input int mode, output int words, output bit saw_done);
        words = 0; saw_done = 0;
        xfer_go = 1;
        step();
        xfer_go = 0;
        for (int c = 0; c < 200 && !saw_done; c++) begin
            cfg_ready = (mode == 0) ? 1'b1 : ((c % 3) != 1);
            if (cfg_valid && cfg_ready) words++;
            step();
            if (cfg_done) saw_done = 1;
        end
        cfg_ready = 0;
    endtask

    initial begin
        int words, cnt;
        bit saw;
        foreach (m_mem[i]) m_mem[i] = EV;
        m_lock = 0; m_rv = 0; m_rej = 0; m_act = 0; m_done = 0; m_rd = '0;
        m_left = 0; m_ptr = 0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!busy && !locked && !cfg_valid && !cfg_done && !rsp_valid && !cmd_reject,
            "R11 reset outputs", {busy, locked, cfg_valid, cfg_done, rsp_valid, cmd_reject}, 0);
        rst_n = 1;
        step();
        issue(2'b01, 4'd9, '0);
        chk(rsp_data == EV, "R11 blank word", rsp_data, EV);

        // R1 write then read, unlocked
        for (int i = 0; i < DEPTH; i++) issue(2'b00, AW'(i), DW'(i * 16'h0111 + 7));
        issue(2'b01, 4'd5, '0);
        chk(rsp_valid && rsp_data == 16'h055C, "R1 read back", rsp_data, 16'h055C);

        // R5 start ignored while unlocked
        xfer_go = 1; step(); xfer_go = 0; step();
        chk(!cfg_valid, "R5 unlocked start", cfg_valid, 0);

        // R3 lock, then refused write and relock
        issue(2'b10, '0, '0);
        chk(locked, "R3 lock set", locked, 1);
        issue(2'b00, 4'd3, 16'h1234);
        chk(cmd_reject, "R3 write refused", cmd_reject, 1);
        issue(2'b10, '0, '0);
        chk(cmd_reject, "R3 relock refused", cmd_reject, 1);

        // R4 locked read
        issue(2'b01, 4'd3, '0);
        chk(rsp_data == FILL && cmd_reject, "R4 fill pattern", rsp_data, FILL);

        // R6 R7 stream with gaps, then without
        run_stream(1, words, saw);
        chk(saw && words == DEPTH, "R7 done after last word", words, DEPTH);
        run_stream(0, words, saw);
        chk(saw && words == DEPTH, "R6 back-to-back stream", words, DEPTH);
        step();

        // R10 wipe during stream
        xfer_go = 1; step(); xfer_go = 0;
        cfg_ready = 1;
        repeat (5) step();
        cfg_ready = 0;
        issue(2'b11, '0, '0);
        chk(!cfg_valid && busy, "R10 abort", cfg_valid, 0);
        // R9 command while busy
        issue(2'b00, 4'd2, 16'h4444);
        chk(cmd_reject && !rsp_valid, "R9 busy refuse", cmd_reject, 1);
        cnt = 2;
        while (busy && cnt < 100) begin
            step();
            if (cfg_done) chk(0, "R10 no done", 1, 0);
            if (busy) cnt++;
        end
        chk(cnt == DEPTH, "R8 wipe length", cnt, DEPTH);
        chk(!locked, "R8 unlocked", locked, 0);
        issue(2'b01, 4'd2, '0);
        chk(rsp_data == EV && !cmd_reject, "R8 blank after wipe", rsp_data, EV);
        issue(2'b01, 4'd3, '0);
        chk(rsp_data == EV, "R8 blank addr3", rsp_data, EV);
        xfer_go = 1; step(); xfer_go = 0; step();
        chk(!cfg_valid, "R5 start after wipe", cfg_valid, 0);

        // R8 wipe while unlocked, then R1 again
        issue(2'b00, 4'd15, 16'hBEEF);
        issue(2'b11, '0, '0);
        issue(2'b01, 4'd15, '0);
        chk(!rsp_valid && cmd_reject, "R9 read while busy", rsp_valid, 0);
        while (busy) step();
        issue(2'b01, 4'd15, '0);
        chk(rsp_data == EV, "R8 unlocked wipe", rsp_data, EV);
        issue(2'b00, 4'd0, 16'h0F0F);
        issue(2'b01, 4'd0, '0);
        chk(rsp_data == 16'h0F0F, "R1 rewrite", rsp_data, 16'h0F0F);
        step();

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule